// File: doc/BRIEF.md
# Bus trace capture control

This block decides, cycle by cycle, whether an on-chip bus trace buffer should record the transfer on the bus. It also owns the time tag counter that the trace logic stamps onto each entry. Three control bits govern it: a trace enable, a force bit and a timer-enable bit. The enable bit starts from two strap pins when reset is released. Software can then rewrite all three bits. The force bit lets tracing continue while the processor is halted in debug mode. The timer-enable bit keeps the time tag counting during that halt. A breakpoint hit drops both of these bits, so the trace stops right after the event of interest.

The block also gates software access to the trace memory and the breakpoint registers. While tracing is enabled, such a request is not forwarded. It reads back as zero, any write is dropped, and an error flag pulses for one cycle. While tracing is disabled, requests pass through unchanged. The trace memory, its pointer and the breakpoint comparators sit outside this block and only consume its qualifier.

Top module: `trace_capture_ctrl`

## Requirements
- R1: While reset is asserted, and until the first clock edge after its release, the enable, force and timer-enable bits, the time tag and the error flag are all zero. On that first edge, enable loads `en_pin_i & ~brk_pin_i`, and a software enable write in that same cycle is ignored.
- R2: `trace_act_o` is high exactly when enable is set and either `dbg_mode_i` is low or the force bit is set. It reacts to `dbg_mode_i` in the same cycle.
- R3: A cycle with `bp_hit_i` high clears both the force bit and the timer-enable bit at the next edge. This holds even when a software write in the same cycle sets them.
- R4: A cycle with `ctl_we_i` high loads the control bits from `ctl_wdata_i` at the next edge, with bit 0 as enable, bit 1 as force and bit 2 as timer-enable. `ctl_rdata_o` returns the current bits in the same layout.
- R5: The time tag advances by one on every edge where `dbg_mode_i` is low or timer-enable is set. On every other edge it holds its value.
- R6: The time tag wraps from all ones to zero.
- R7: While enable is set, `mem_req_o`, `mem_we_o` and `mem_gnt_o` stay low and `mem_rdata_o` reads zero.
- R8: Each cycle with `mem_req_i` high while enable is set raises `mem_err_o` for the following cycle only.
- R9: While enable is clear, a request is forwarded with its write flag, `mem_gnt_o` follows `mem_req_i`, `mem_rdata_i` is passed to `mem_rdata_o`, and no error is raised.
- R10: Neither `bp_hit_i` nor `dbg_mode_i` changes the enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_pin_i | input | 1 | Strap pin requesting tracing after reset |
| brk_pin_i | input | 1 | Strap pin that blocks tracing after reset |
| dbg_mode_i | input | 1 | Processor is halted in debug mode |
| bp_hit_i | input | 1 | Breakpoint hit pulse |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 3 | Control write data {timer-enable, force, enable} |
| ctl_rdata_o | output | 3 | Control register contents, same layout |
| trace_act_o | output | 1 | Record the current bus transfer |
| ttag_o | output | TTAG_W | Time tag counter value |
| mem_req_i | input | 1 | Software access request to trace memory or breakpoint registers |
| mem_we_i | input | 1 | Access is a write |
| mem_rdata_i | input | DATA_W | Read data from trace memory side |
| mem_req_o | output | 1 | Forwarded request |
| mem_we_o | output | 1 | Forwarded write flag |
| mem_gnt_o | output | 1 | Access granted this cycle |
| mem_rdata_o | output | DATA_W | Read data returned to software |
| mem_err_o | output | 1 | One-cycle pulse after a denied access |

## Verification
The bench targets a software write that sets the force bit in the same cycle as a breakpoint hit. A design that gave the write priority would keep tracing after the breakpoint. It also checks the first edge after reset, where the strap pins must win over any write. A design that loaded the straps on a later edge, or from the wrong polarity of the break pin, would start with the wrong enable state. The time tag is watched across debug entry, with and without timer-enable, and across its wrap. An off-by-one freeze or a missing wrap would show up as a miscount. Denied accesses are tried in runs of more than one cycle, which catches an error flag that is held high or dropped, and read data that leaks through while tracing is enabled.

// File: rtl/trace_ctrl_pkg.sv
package trace_ctrl_pkg;
  localparam int CTL_W = 3;

  // bit 0 enable, bit 1 force, bit 2 timer-enable
  typedef struct packed {
    logic ten;
    logic frc;
    logic en;
  } ctl_t;
endpackage

// File: rtl/trace_ctl_regs.sv
module trace_ctl_regs
  import trace_ctrl_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_pin_i,
  input  logic brk_pin_i,
  input  logic bp_hit_i,
  input  logic we_i,
  input  ctl_t wdata_i,
  output ctl_t q_o
);
  logic init_q;
  ctl_t q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q <= 1'b1;
      q      <= '0;
    end else begin
      init_q <= 1'b0;
      // strap load on the first edge out of reset takes priority over software
      if (init_q)    q.en <= en_pin_i & ~brk_pin_i;
      else if (we_i) q.en <= wdata_i.en;
      if (bp_hit_i) begin
        q.frc <= 1'b0;
        q.ten <= 1'b0;
      end else if (we_i) begin
        q.frc <= wdata_i.frc;
        q.ten <= wdata_i.ten;
      end
    end
  end

  assign q_o = q;

  assert_bp_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bp_hit_i |=> (!q.frc && !q.ten));

  assert_en_stable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && !init_q) |=> $stable(q.en));

  assert_write_takes_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !bp_hit_i) |=> (q.frc == $past(wdata_i.frc) && q.ten == $past(wdata_i.ten)));
endmodule

// File: rtl/trace_ttag_cnt.sv
module trace_ttag_cnt #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] ONE = W'(1);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (run_i) cnt_q <= cnt_q + ONE;
  end

  assign cnt_o = cnt_q;

  assert_frozen_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(cnt_q));

  assert_step_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && (&cnt_q)) |=> (cnt_q == '0));
endmodule

// File: rtl/trace_acc_gate.sv
module trace_acc_gate #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          busy_i,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [DW-1:0] rdata_i,
  output logic          req_o,
  output logic          we_o,
  output logic          gnt_o,
  output logic [DW-1:0] rdata_o,
  output logic          err_o
);
  logic err_q;

  assign gnt_o   = req_i & ~busy_i;
  assign req_o   = gnt_o;
  assign we_o    = gnt_o & we_i;
  assign rdata_o = busy_i ? '0 : rdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= req_i & busy_i;
  end

  assign err_o = err_q;

  assert_blocked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> (!req_o && !we_o && !gnt_o && rdata_o == '0));

  assert_err_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && busy_i) |=> err_o);

  assert_no_err_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |=> !err_o);
endmodule

// File: rtl/trace_capture_ctrl.sv
module trace_capture_ctrl
  import trace_ctrl_pkg::*;
#(
  parameter int TTAG_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_pin_i,
  input  logic              brk_pin_i,
  input  logic              dbg_mode_i,
  input  logic              bp_hit_i,
  input  logic              ctl_we_i,
  input  logic [CTL_W-1:0]  ctl_wdata_i,
  output logic [CTL_W-1:0]  ctl_rdata_o,
  output logic              trace_act_o,
  output logic [TTAG_W-1:0] ttag_o,
  input  logic              mem_req_i,
  input  logic              mem_we_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic              mem_gnt_o,
  output logic [DATA_W-1:0] mem_rdata_o,
  output logic              mem_err_o
);
  ctl_t ctl;

  trace_ctl_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_pin_i  (en_pin_i),
    .brk_pin_i (brk_pin_i),
    .bp_hit_i  (bp_hit_i),
    .we_i      (ctl_we_i),
    .wdata_i   (ctl_t'(ctl_wdata_i)),
    .q_o       (ctl)
  );

  trace_ttag_cnt #(.W(TTAG_W)) u_ttag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (~dbg_mode_i | ctl.ten),
    .cnt_o  (ttag_o)
  );

  trace_acc_gate #(.DW(DATA_W)) u_gate (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .busy_i  (ctl.en),
    .req_i   (mem_req_i),
    .we_i    (mem_we_i),
    .rdata_i (mem_rdata_i),
    .req_o   (mem_req_o),
    .we_o    (mem_we_o),
    .gnt_o   (mem_gnt_o),
    .rdata_o (mem_rdata_o),
    .err_o   (mem_err_o)
  );

  assign ctl_rdata_o = ctl;
  assign trace_act_o = ctl.en & (~dbg_mode_i | ctl.frc);

  assert_dbg_suspend_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_mode_i && !ctl_rdata_o[1]) |-> !trace_act_o);

  assert_act_needs_en_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trace_act_o |-> ctl_rdata_o[0]);
endmodule

// File: tb/sim_trace_capture_ctrl.sv
module sim_trace_capture_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 8;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n, en_pin, brk_pin, dbg, bp, we, mreq, mwe;
  logic [2:0]    wdata;
  logic [DW-1:0] mrdata;
  logic [2:0]    ctl_rd;
  logic          act, mreq_o, mwe_o, mgnt, merr;
  logic [TW-1:0] ttag;
  logic [DW-1:0] mrdata_o;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trace_capture_ctrl #(.TTAG_W(TW), .DATA_W(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_pin_i(en_pin), .brk_pin_i(brk_pin),
    .dbg_mode_i(dbg), .bp_hit_i(bp), .ctl_we_i(we), .ctl_wdata_i(wdata),
    .ctl_rdata_o(ctl_rd), .trace_act_o(act), .ttag_o(ttag),
    .mem_req_i(mreq), .mem_we_i(mwe), .mem_rdata_i(mrdata),
    .mem_req_o(mreq_o), .mem_we_o(mwe_o), .mem_gnt_o(mgnt),
    .mem_rdata_o(mrdata_o), .mem_err_o(merr)
  );

  // behavioural reference
  bit m_en, m_frc, m_ten, m_init, m_err;
  int m_tt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_frc = 0; m_ten = 0; m_init = 1; m_err = 0; m_tt = 0;
    end else begin
      bit o_en, o_ten, o_init;
      o_en = m_en; o_ten = m_ten; o_init = m_init;
      if (!dbg || o_ten) m_tt = (m_tt + 1) % (1 << TW);
      m_err = mreq && o_en;
      if (o_init)  m_en = en_pin && !brk_pin;
      else if (we) m_en = wdata[0];
      if (bp) begin m_frc = 0; m_ten = 0; end
      else if (we) begin m_frc = wdata[1]; m_ten = wdata[2]; end
      m_init = 0;
    end
  end

  task automatic cmp(string tag, logic [63:0] act_v, logic [63:0] exp_v);
    vectors++;
    if (act_v !== exp_v) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act_v, exp_v, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      cmp("R1/R4 ctl_rdata", 64'(ctl_rd), 64'({m_ten, m_frc, m_en}));
      cmp("R2 trace_act", 64'(act), 64'(m_en && (!dbg || m_frc)));
      cmp("R5/R6 ttag", 64'(ttag), 64'(m_tt));
      cmp("R7/R9 mem_req_o", 64'(mreq_o), 64'(mreq && !m_en));
      cmp("R7/R9 mem_we_o", 64'(mwe_o), 64'(mreq && mwe && !m_en));
      cmp("R7/R9 mem_gnt_o", 64'(mgnt), 64'(mreq && !m_en));
      cmp("R7/R9 mem_rdata_o", 64'(mrdata_o), m_en ? 64'd0 : 64'(mrdata));
      cmp("R8 mem_err_o", 64'(merr), 64'(m_err));
    end
  end

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic do_reset(bit e, bit b);
    rst_n = 0; en_pin = e; brk_pin = b;
    step(2);
    rst_n = 1;
    step(1);
  endtask

  task automatic wr(logic [2:0] d, bit hit = 0);
    we = 1; wdata = d; bp = hit;
    step(1);
    we = 0; bp = 0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 0; en_pin = 1; brk_pin = 0; dbg = 0; bp = 0; we = 0; wdata = 0;
    mreq = 0; mwe = 0; mrdata = 32'h1234_5678;
    // R1: write on the strap-load edge must be ignored for enable
    #1; step(2);
    rst_n = 1; we = 1; wdata = 3'b000;
    step(1); we = 0;
    step(5);
    // R2/R5: debug without force suspends trace and freezes tag
    dbg = 1; step(4);
    // force on: tracing resumes, tag stays frozen
    wr(3'b011); step(4);
    // timer-enable: tag runs in debug
    wr(3'b111); step(4);
    // R3: breakpoint clears force and timer-enable
    bp = 1; step(1); bp = 0; step(3);
    // R3: same-cycle set and hit, hit wins
    wr(3'b111, 1); step(3);
    // R4: software clear
    wr(3'b111); step(2); wr(3'b001); step(2);
    dbg = 0; step(2);
    // R7/R8: denied accesses, multi-cycle run
    mreq = 1; mwe = 1; mrdata = 32'hA5A5_5A5A; step(3);
    mreq = 0; step(2);
    mreq = 1; mwe = 0; step(1); mreq = 0; step(2);
    // R9: disable then access
    wr(3'b000); step(1);
    mreq = 1; mwe = 0; mrdata = 32'hDEAD_BEEF; step(2);
    mwe = 1; step(2); mreq = 0; step(1);
    // R10: breakpoint and debug leave enable alone
    bp = 1; dbg = 1; step(1); bp = 0; step(2); dbg = 0; step(1);
    wr(3'b001); bp = 1; step(1); bp = 0; step(2);
    // R1 straps
    do_reset(1, 1); step(3);
    do_reset(0, 0); step(3);
    do_reset(0, 1); step(3);
    do_reset(1, 0); step(3);
    // R6: wrap of the time tag
    step(600);
    // mixed stimulus
    for (int i = 0; i < 2000; i++) begin
      dbg    = ($urandom % 3) == 0;
      bp     = ($urandom % 11) == 0;
      we     = ($urandom % 5) == 0;
      wdata  = 3'($urandom);
      mreq   = ($urandom % 3) == 0;
      mwe    = 1'($urandom);
      mrdata = $urandom;
      step(1);
    end
    dbg = 0; bp = 0; we = 0; mreq = 0;
    step(2);
    finish_run();
  end
endmodule